// File: doc/BRIEF.md
# Serial receiver with status flags

This block is the receive half of an asynchronous serial port. It watches an NRZ line with a one-cycle enable pulse that arrives sixteen times per bit period. It finds and confirms the start bit, then gathers five to eight data bits least significant bit first. It can also take a parity bit, and it checks the stop bit. It passes the finished character to a holding register. Status flags report a waiting character, a parity error, a framing error and an overrun.

A flow-control output asks the far end to pause. It can drop as soon as a frame begins, or only once a whole character is waiting. An echo path copies the incoming line back out. A level interrupt request tells the host that a character is ready. The host takes the character by pulsing a read strobe.

The receiver FSM has five states:

- `S_IDLE` waits for a low line on a tick while reception is allowed, then goes to `S_START`.
- `S_START` resamples the line on the eighth tick. A high line means a false start, and the FSM returns to `S_IDLE`. A low line moves it to `S_DATA`.
- `S_DATA` samples one bit every sixteen ticks. After the last data bit it goes to `S_PAR` when parity is on, otherwise to `S_STOP`.
- `S_PAR` samples the parity bit and goes to `S_STOP`.
- `S_STOP` samples the stop bit, hands the character over and returns to `S_IDLE`.

From any state, losing the enable or the carrier forces `S_IDLE`.

Top module: `serial_rx_path`

## Requirements
- R1: A low line on a tick in idle starts a frame. The line is resampled 8 ticks later. If it is high then, the frame is dropped and nothing is stored.
- R2: Data bits are taken LSB first, one every 16 ticks at the bit centre. `wlen` gives 8, 7, 6 or 5 data bits for codes 0, 1, 2 or 3. Unused high bits of `rx_data` are 0.
- R3: With `par_en`=1, one parity bit follows the data and is never stored. `par_sel` 00 is odd and 01 is even; for these a mismatch sets `parity_err`. Codes 10 (mark) and 11 (space) expect the bit but never check it.
- R4: A stop bit sampled low sets `framing_err`.
- R5: `rx_full` sets when a character is stored and clears on a `rd_strobe` pulse.
- R6: A character that completes while `rx_full` is set is discarded. It sets `overrun`, and the held character is kept.
- R7: `parity_err`, `framing_err` and `overrun` stay set through reads. They clear only when a character is stored error-free after a read. A stored character with an error sets its flag(s) without clearing the others.
- R8: Frames are received only while `rx_enable`=1 and `dcd_n`=0. Otherwise no frame starts, and a frame in progress is abandoned.
- R9: `fc_n` is low while `rx_full` is set. With `fc_mode`=1 it is also low from start detection to the end of the frame.
- R10: With `echo_en`=1 and `tx_ctl`=00, `echo_txd` follows the line 3 clocks later. Otherwise it stays high.
- R11: `rx_irq` is high when `rx_full`=1, `irq_mask`=0 and `rx_enable`=1, and is low otherwise. Errors raise no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | One-cycle pulse, 16 per bit period |
| rxd_in | input | 1 | Serial line, idle high |
| dcd_n | input | 1 | Carrier detect, active low |
| rx_enable | input | 1 | Receiver and interrupt enable |
| irq_mask | input | 1 | 1 masks the receive interrupt |
| fc_mode | input | 1 | 0: flow control drops after the byte; 1: drops at the start bit |
| echo_en | input | 1 | Echo request |
| tx_ctl | input | 2 | Transmitter control code; echo is legal only at 00 |
| wlen | input | 2 | Word length code (8 minus the code) |
| par_en | input | 1 | Parity bit present |
| par_sel | input | 2 | Parity kind: 00 odd, 01 even, 10 mark, 11 space |
| rd_strobe | input | 1 | Data register read pulse |
| rx_data | output | 8 | Held character |
| rx_full | output | 1 | Character waiting |
| parity_err | output | 1 | Parity error flag |
| framing_err | output | 1 | Framing error flag |
| overrun | output | 1 | Overrun flag |
| fc_n | output | 1 | Flow control, low asks the sender to pause |
| echo_txd | output | 1 | Echoed line |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The bench sends a short low glitch. A design that trusts the first low sample would store a garbage character. It sends a bad-parity character, then a clean one without reading, then reads and sends another clean one. A design that cleared the flags on the read, or on any later character, would lose them too early. A design that overwrote the held byte on overrun would show the wrong data. A frame whose stop bit is low leaves the line low after the stop-bit centre, which tests that this spurious start is rejected. The remaining tests cover the mark-parity bit, which must not be checked, the carrier gate and both flow-control modes. Echo is also tried with a non-zero transmitter code, where it must stay off.

// File: rtl/srx_pkg.sv
package srx_pkg;
    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_START = 3'd1,
        S_DATA  = 3'd2,
        S_PAR   = 3'd3,
        S_STOP  = 3'd4
    } rx_state_e;

    typedef enum logic [1:0] {
        PAR_ODD   = 2'b00,
        PAR_EVEN  = 2'b01,
        PAR_MARK  = 2'b10,
        PAR_SPACE = 2'b11
    } par_mode_e;
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
    parameter int STAGES = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic d_out
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d_in};
    end

    assign d_out = chain[STAGES-1];
endmodule

// File: rtl/srx_fsm.sv
module srx_fsm
    import srx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              line,
    input  logic              run,
    input  logic [1:0]        wlen,
    input  logic              par_en,
    input  logic [1:0]        par_sel,
    output logic              deliver,
    output logic [DATA_W-1:0] dl_data,
    output logic              dl_pe,
    output logic              dl_fe,
    output logic              in_frame
);
    localparam int CNT_W = $clog2(OVS);
    localparam int IDX_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] HALF_M1 = CNT_W'(OVS/2 - 1);
    localparam logic [CNT_W-1:0] FULL_M1 = CNT_W'(OVS - 1);

    rx_state_e          state, nxt;
    logic [CNT_W-1:0]   cnt;
    logic [IDX_W-1:0]   bit_idx;
    logic [DATA_W-1:0]  shreg;
    logic               par_bit;
    logic               sample_pt;
    logic [IDX_W-1:0]   last_idx;
    logic               par_odd;

    assign last_idx  = IDX_W'(DATA_W - 1) - IDX_W'(wlen);
    assign sample_pt = run && tick &&
                       (cnt == ((state == S_START) ? HALF_M1 : FULL_M1));
    assign par_odd   = ^shreg ^ par_bit;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        if (!run) begin
            nxt = S_IDLE;
        end else begin
            unique case (state)
                S_IDLE:  if (tick && !line) nxt = S_START;
                S_START: if (sample_pt) nxt = line ? S_IDLE : S_DATA;
                S_DATA:  if (sample_pt && bit_idx == last_idx)
                             nxt = par_en ? S_PAR : S_STOP;
                S_PAR:   if (sample_pt) nxt = S_STOP;
                S_STOP:  if (sample_pt) nxt = S_IDLE;
                default: nxt = S_IDLE;
            endcase
        end
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            bit_idx <= '0;
            shreg   <= '0;
            par_bit <= 1'b0;
            deliver <= 1'b0;
            dl_data <= '0;
            dl_pe   <= 1'b0;
            dl_fe   <= 1'b0;
        end else begin
            deliver <= 1'b0;
            if (nxt != state)  cnt <= '0;
            else if (tick)     cnt <= cnt + 1'b1;

            if (sample_pt) begin
                unique case (state)
                    S_START: begin
                        bit_idx <= '0;
                        shreg   <= '0;
                    end
                    S_DATA: begin
                        shreg   <= {line, shreg[DATA_W-1:1]};
                        bit_idx <= bit_idx + 1'b1;
                    end
                    S_PAR: par_bit <= line;
                    S_STOP: begin
                        deliver <= 1'b1;
                        dl_data <= shreg >> wlen;
                        dl_fe   <= !line;
                        if (!par_en)
                            dl_pe <= 1'b0;
                        else if (par_mode_e'(par_sel) == PAR_ODD)
                            dl_pe <= !par_odd;
                        else if (par_mode_e'(par_sel) == PAR_EVEN)
                            dl_pe <= par_odd;
                        else
                            dl_pe <= 1'b0;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign in_frame = (state != S_IDLE);
endmodule

// File: rtl/srx_flags.sv
module srx_flags #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              deliver,
    input  logic [DATA_W-1:0] dl_data,
    input  logic              dl_pe,
    input  logic              dl_fe,
    input  logic              rd_strobe,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_full,
    output logic              parity_err,
    output logic              framing_err,
    output logic              overrun
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data     <= '0;
            rx_full     <= 1'b0;
            parity_err  <= 1'b0;
            framing_err <= 1'b0;
            overrun     <= 1'b0;
        end else if (deliver) begin
            if (rx_full && !rd_strobe) begin
                overrun <= 1'b1;
            end else begin
                rx_data <= dl_data;
                rx_full <= 1'b1;
                if (dl_pe || dl_fe) begin
                    parity_err  <= parity_err  | dl_pe;
                    framing_err <= framing_err | dl_fe;
                end else begin
                    parity_err  <= 1'b0;
                    framing_err <= 1'b0;
                    overrun     <= 1'b0;
                end
            end
        end else if (rd_strobe) begin
            rx_full <= 1'b0;
        end
    end
endmodule

// File: rtl/serial_rx_path.sv
module serial_rx_path #(
    parameter int DATA_W      = 8,
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic              rxd_in,
    input  logic              dcd_n,
    input  logic              rx_enable,
    input  logic              irq_mask,
    input  logic              fc_mode,
    input  logic              echo_en,
    input  logic [1:0]        tx_ctl,
    input  logic [1:0]        wlen,
    input  logic              par_en,
    input  logic [1:0]        par_sel,
    input  logic              rd_strobe,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_full,
    output logic              parity_err,
    output logic              framing_err,
    output logic              overrun,
    output logic              fc_n,
    output logic              echo_txd,
    output logic              rx_irq
);
    logic              line_s;
    logic              run;
    logic              deliver;
    logic [DATA_W-1:0] rcv_data;
    logic              rcv_pe;
    logic              rcv_fe;
    logic              in_frame;

    assign run = rx_enable && !dcd_n;

    srx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_in(rxd_in), .d_out(line_s)
    );

    srx_fsm #(.DATA_W(DATA_W), .OVS(OVS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(tick16), .line(line_s), .run(run),
        .wlen(wlen), .par_en(par_en), .par_sel(par_sel),
        .deliver(deliver), .dl_data(rcv_data), .dl_pe(rcv_pe),
        .dl_fe(rcv_fe), .in_frame(in_frame)
    );

    srx_flags #(.DATA_W(DATA_W)) u_flags (
        .clk(clk), .rst_n(rst_n), .deliver(deliver), .dl_data(rcv_data),
        .dl_pe(rcv_pe), .dl_fe(rcv_fe), .rd_strobe(rd_strobe),
        .rx_data(rx_data), .rx_full(rx_full), .parity_err(parity_err),
        .framing_err(framing_err), .overrun(overrun)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) echo_txd <= 1'b1;
        else        echo_txd <= (echo_en && tx_ctl == 2'b00) ? line_s : 1'b1;
    end

    assign fc_n   = !(rx_full || (fc_mode && in_frame));
    assign rx_irq = rx_full && !irq_mask && rx_enable;
endmodule

// File: rtl/srx_checker.sv
module srx_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dcd_n,
    input logic              irq_mask,
    input logic [1:0]        wlen,
    input logic              rd_strobe,
    input logic              deliver,
    input logic [DATA_W-1:0] rcv_data,
    input logic              in_frame,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_full,
    input logic              parity_err,
    input logic              overrun,
    input logic              fc_n,
    input logic              rx_irq
);
    assert_unused_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (deliver && wlen == 2'b11) |-> (rcv_data[DATA_W-1:DATA_W-3] == '0));

    assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !deliver) |=> !rx_full);

    assert_overrun_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (deliver && rx_full && !rd_strobe) |=> ($stable(rx_data) && overrun));

    assert_sticky_parity_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (parity_err && !deliver) |=> parity_err);

    assert_no_carrier_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dcd_n && !in_frame) |=> !in_frame);

    assert_fc_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full |-> !fc_n);

    assert_irq_mask_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_mask |-> !rx_irq);
endmodule

bind serial_rx_path srx_checker #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .dcd_n(dcd_n), .irq_mask(irq_mask),
    .wlen(wlen), .rd_strobe(rd_strobe), .deliver(deliver),
    .rcv_data(rcv_data), .in_frame(in_frame), .rx_data(rx_data),
    .rx_full(rx_full), .parity_err(parity_err), .overrun(overrun),
    .fc_n(fc_n), .rx_irq(rx_irq)
);

// File: tb/tb_serial_rx_path.sv
`timescale 1ns/1ps
module tb_serial_rx_path;
    localparam int BITCLK = 64;   // 16 ticks, one tick every 4 clocks

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       rxd_in = 1'b1;
    logic       dcd_n = 1'b0;
    logic       rx_enable = 1'b1;
    logic       irq_mask = 1'b0;
    logic       fc_mode = 1'b0;
    logic       echo_en = 1'b0;
    logic [1:0] tx_ctl = 2'b00;
    logic [1:0] wlen = 2'b00;
    logic       par_en = 1'b0;
    logic [1:0] par_sel = 2'b00;
    logic       rd_strobe = 1'b0;
    logic [7:0] rx_data;
    logic       rx_full, parity_err, framing_err, overrun, fc_n, echo_txd, rx_irq;

    int errors = 0;
    int checks = 0;
    logic [1:0] tdiv = '0;

    always #4 clk = ~clk;

    always_ff @(posedge clk) begin
        tdiv   <= tdiv + 1'b1;
        tick16 <= (tdiv == 2'd3);
    end

    serial_rx_path dut (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd_in(rxd_in),
        .dcd_n(dcd_n), .rx_enable(rx_enable), .irq_mask(irq_mask),
        .fc_mode(fc_mode), .echo_en(echo_en), .tx_ctl(tx_ctl), .wlen(wlen),
        .par_en(par_en), .par_sel(par_sel), .rd_strobe(rd_strobe),
        .rx_data(rx_data), .rx_full(rx_full), .parity_err(parity_err),
        .framing_err(framing_err), .overrun(overrun), .fc_n(fc_n),
        .echo_txd(echo_txd), .rx_irq(rx_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hold_bit(input logic v);
        @(negedge clk) rxd_in = v;
        repeat (BITCLK - 1) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input int nb, input bit with_par,
                              input logic pbit, input logic stopv);
        hold_bit(1'b0);
        for (int i = 0; i < nb; i++) hold_bit(d[i]);
        if (with_par) hold_bit(pbit);
        hold_bit(stopv);
        hold_bit(1'b1);
    endtask

    task automatic read_pulse();
        @(negedge clk) rd_strobe = 1'b1;
        @(negedge clk) rd_strobe = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R5 reset full", rx_full, 0);
        check("R7 reset flags", {parity_err, framing_err, overrun}, 0);
        check("R9 reset fc_n", fc_n, 1);
        check("R11 reset irq", rx_irq, 0);
        check("R10 reset echo", echo_txd, 1);
    endtask

    task automatic t_basic();
        send_frame(8'hA5, 8, 0, 0, 1);
        check("R2 data 8 bit", rx_data, 8'hA5);
        check("R5 full set", rx_full, 1);
        check("R9 fc low while full", fc_n, 0);
        check("R11 irq raised", rx_irq, 1);
        irq_mask = 1'b1;
        @(negedge clk);
        check("R11 irq masked", rx_irq, 0);
        irq_mask = 1'b0;
        read_pulse();
        check("R5 read clears full", rx_full, 0);
        check("R9 fc released", fc_n, 1);
        check("R11 irq dropped", rx_irq, 0);
    endtask

    task automatic t_wlen5();
        wlen = 2'b11;
        send_frame(8'h1D, 5, 0, 0, 1);
        check("R2 five bits upper zero", rx_data, 8'h1D);
        read_pulse();
        wlen = 2'b01;
        send_frame(8'h55, 7, 0, 0, 1);
        check("R2 seven bits", rx_data, 8'h55);
        read_pulse();
        wlen = 2'b00;
    endtask

    task automatic t_parity_overrun();
        wlen = 2'b01; par_en = 1'b1;
        par_sel = 2'b01;                       // even
        send_frame(8'h35, 7, 1, 1'b0, 1);      // 4 ones, even ok
        check("R3 even ok data stripped", rx_data, 8'h35);
        check("R3 even ok no pe", parity_err, 0);
        read_pulse();
        par_sel = 2'b10;                       // mark, bit not checked
        send_frame(8'h35, 7, 1, 1'b0, 1);
        check("R3 mark unchecked", parity_err, 0);
        read_pulse();
        par_sel = 2'b00;                       // odd, send wrong bit
        send_frame(8'h35, 7, 1, 1'b0, 1);
        check("R3 odd mismatch", parity_err, 1);
        check("R3 data kept", rx_data, 8'h35);
        send_frame(8'h12, 7, 1, 1'b1, 1);      // clean, not read
        check("R6 overrun set", overrun, 1);
        check("R6 held data kept", rx_data, 8'h35);
        check("R7 pe survives overrun", parity_err, 1);
        read_pulse();
        check("R7 read alone keeps flags", {parity_err, overrun}, 2'b11);
        send_frame(8'h13, 7, 1, 1'b0, 1);      // 3 ones, odd ok
        check("R7 clean char clears", {parity_err, framing_err, overrun}, 0);
        check("R7 new data", rx_data, 8'h13);
        read_pulse();
        par_en = 1'b0; wlen = 2'b00;
    endtask

    task automatic t_framing();
        send_frame(8'h3C, 8, 0, 0, 1'b0);
        hold_bit(1'b1);
        check("R4 framing set", framing_err, 1);
        check("R1 spurious start after low stop dropped", rx_data, 8'h3C);
        read_pulse();
        check("R1 nothing stored after glitch", rx_full, 0);
        send_frame(8'h81, 8, 0, 0, 1);
        check("R4 framing cleared by clean char", framing_err, 0);
        read_pulse();
    endtask

    task automatic t_false_start_fc();
        fc_mode = 1'b1;
        @(negedge clk) rxd_in = 1'b0;
        repeat (16) @(negedge clk);
        check("R9 fc drops at start", fc_n, 0);
        rxd_in = 1'b1;
        repeat (3 * BITCLK) @(negedge clk);
        check("R1 false start ignored", rx_full, 0);
        check("R9 fc back high after false start", fc_n, 1);
        send_frame(8'h6E, 8, 0, 0, 1);
        check("R9 start mode frame stored", rx_data, 8'h6E);
        read_pulse();
        fc_mode = 1'b0;
    endtask

    task automatic t_gate();
        dcd_n = 1'b1;
        send_frame(8'h77, 8, 0, 0, 1);
        check("R8 no carrier no receive", rx_full, 0);
        dcd_n = 1'b0;
        rx_enable = 1'b0;
        send_frame(8'h77, 8, 0, 0, 1);
        check("R8 disabled no receive", rx_full, 0);
        rx_enable = 1'b1;
    endtask

    task automatic t_echo();
        echo_en = 1'b1; tx_ctl = 2'b00;
        @(negedge clk) rxd_in = 1'b0;
        repeat (8) @(negedge clk);
        check("R10 echo follows low", echo_txd, 0);
        rxd_in = 1'b1;
        repeat (8) @(negedge clk);
        check("R10 echo follows high", echo_txd, 1);
        tx_ctl = 2'b01;
        rxd_in = 1'b0;
        repeat (8) @(negedge clk);
        check("R10 echo blocked by tx_ctl", echo_txd, 1);
        rxd_in = 1'b1;
        echo_en = 1'b0; tx_ctl = 2'b00;
        repeat (4 * BITCLK) @(negedge clk);
        if (rx_full) read_pulse();
        check("R10 flags clean after echo", {parity_err, framing_err, overrun}, 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_basic();
        t_wlen5();
        t_parity_overrun();
        t_framing();
        t_false_start_fc();
        t_gate();
        t_echo();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule